// File: doc/BRIEF.md
# Second/Minute Countdown Watchdog

This block is a watchdog counter placed behind a small bank of byte-wide configuration registers. Software writes a timeout value, split into a low and a high byte, and the counter starts to run down. A configuration bit picks whether one unit of the count is one second or one minute. The one-second time base comes in as a single-cycle tick input. In minute mode an internal divide-by-60 stage turns those ticks into one decrement per minute. That divider is cleared on every reload, so each new period starts on a clean minute boundary.

Writing the low byte loads the full value, made of the stored high byte and the newly written low byte, and restarts the count. Software uses that same write as the keep-alive. A loaded value of zero stops the watchdog. When the count runs out, the block sets a sticky expiry flag in the control register. It also fires a fixed-length pulse on each reset or timeout output whose enable bit is set in the configuration register. The counter then stays at zero until software writes the low byte again. The register decode front end and the tick source are outside the block. Write strobe, address and data arrive as inputs, and a combinational read port returns the register contents.

Top module: `sm_watchdog`

## Requirements
- R1: After reset every register reads zero, all pulse outputs are low, the expiry flag is clear, and the counter is stopped, so ticks do not set the flag.
- R2: The configuration register (address 0x72) stores and reads back all 8 bits. This includes the 4-bit interrupt-select field in bits 3..0, which has no other effect. The timeout low byte (0x73) and high byte (0x74) also read back as written. In the 8-bit variant the high byte reads zero.
- R3: With configuration bit 7 set (second units), writing a nonzero low byte N sets the expiry flag on exactly the N-th tick after the write and on no earlier tick.
- R4: With configuration bit 7 clear (minute units), the flag sets on exactly the 60·N-th tick after the write. A reload clears any ticks already gathered toward the next minute.
- R5: Writing a low byte that makes the combined value zero stops the counter, and no later tick sets the flag.
- R6: Rewriting the low byte before expiry restarts the full period (keep-alive).
- R7: The expiry flag is bit 0 of the control register (0x71). It is sticky. Writing 1 to that bit clears it, and writing 0 leaves it unchanged.
- R8: After expiry the counter stays stopped at zero, and further ticks cause no second expiry until the low byte is rewritten.
- R9: With configuration bit 6 set, the keyboard-reset output is high for exactly PULSE_CYC cycles, starting the cycle after the expiring tick. With the bit clear, it stays low.
- R10: Configuration bit 4 governs the power-good reset output in the same way.
- R11: Configuration bit 5 governs the timeout output in the same way.
- R12: The loaded value is high byte · 256 + low byte. Writing the high byte alone does not reload or disturb a running count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_1s | input | 1 | One-cycle pulse once per second |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 8 | Register write address |
| wr_data | input | 8 | Register write data |
| rd_addr | input | 8 | Register read address |
| rd_data | output | 8 | Combinational read data |
| expired_o | output | 1 | Sticky expiry flag |
| kbd_rst_o | output | 1 | Keyboard-style reset pulse |
| pwrgood_rst_o | output | 1 | Power-good reset pulse |
| tmo_o | output | 1 | Timeout output pulse |

## Verification
The bench counts ticks right up to the expiry boundary, at N−1 and at N ticks, in both unit modes. A design that is off by one, or that decrements on a clock instead of on a tick, fails at the missed boundary. In minute mode the divider is part-filled before a reload, so a design that keeps stale divider state expires about half a minute early. The bench also checks that a lone high-byte write leaves the running count alone, that writing 0 to the flag does not clear it, and that the counter does not re-arm after expiry. Each pulse output is measured cycle by cycle, which catches a stretch that is too long or too short and any output that fires while its enable bit is clear.

// File: rtl/wdt_pkg.sv
// Shared constants and types for the countdown watchdog.
// Configuration bit positions are fixed because software and the pulse
// routing both decode them.
package wdt_pkg;
    localparam int CFG_SEC_BIT  = 7;  // 1: second units, 0: minute units
    localparam int CFG_KBD_BIT  = 6;  // keyboard reset enable
    localparam int CFG_TOUT_BIT = 5;  // timeout output enable
    localparam int CFG_PWR_BIT  = 4;  // power-good reset enable
    localparam int ST_FLAG_BIT  = 0;  // expiry flag in control register
    localparam int N_PULSE_OUT  = 3;  // number of routed pulse outputs

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_CTRL,
        SEL_CFG,
        SEL_LO,
        SEL_HI
    } reg_sel_e;

    // Enable bit in the configuration register for pulse output k
    // (0: keyboard reset, 1: power-good reset, 2: timeout output).
    function automatic int pulse_en_bit(input int k);
        case (k)
            0:       return CFG_KBD_BIT;
            1:       return CFG_PWR_BIT;
            default: return CFG_TOUT_BIT;
        endcase
    endfunction
endpackage

// File: rtl/wdt_regs.sv
// Register bank of the watchdog: control (sticky expiry flag, W1C),
// configuration byte, timeout low and high bytes.
// Assumes one write per cycle; a low-byte write produces a load request
// with the combined value. CNT_W must lie between 8 and 16.
module wdt_regs
    import wdt_pkg::*;
#(
    parameter int         CNT_W     = 16,
    parameter logic [7:0] ADDR_CTRL = 8'h71,
    parameter logic [7:0] ADDR_CFG  = 8'h72,
    parameter logic [7:0] ADDR_LO   = 8'h73,
    parameter logic [7:0] ADDR_HI   = 8'h74
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [7:0]       wr_addr,
    input  logic [7:0]       wr_data,
    input  logic [7:0]       rd_addr,
    input  logic             expire,
    output logic [7:0]       rd_data,
    output logic [7:0]       cfg_q,
    output logic             status_q,
    output logic             load,
    output logic [CNT_W-1:0] load_val
);
    localparam int HI_W = CNT_W - 8;

    function automatic reg_sel_e decode(input logic [7:0] a);
        if (a == ADDR_CTRL)     return SEL_CTRL;
        else if (a == ADDR_CFG) return SEL_CFG;
        else if (a == ADDR_LO)  return SEL_LO;
        else if (a == ADDR_HI)  return SEL_HI;
        else                    return SEL_NONE;
    endfunction

    reg_sel_e   wsel;
    logic [7:0] lo_q;
    logic [7:0] hi_rd;
    logic       clr_req;

    assign wsel    = wr_en ? decode(wr_addr) : SEL_NONE;
    assign load    = (wsel == SEL_LO);
    assign clr_req = (wsel == SEL_CTRL) && wr_data[ST_FLAG_BIT];

    // Configuration byte storage.
    always_ff @(posedge clk) begin
        if (!rst_n)              cfg_q <= 8'h00;
        else if (wsel == SEL_CFG) cfg_q <= wr_data;
    end

    // Low timeout byte, kept for read-back.
    always_ff @(posedge clk) begin
        if (!rst_n)    lo_q <= 8'h00;
        else if (load) lo_q <= wr_data;
    end

    // Sticky expiry flag: set wins over a same-cycle clear.
    always_ff @(posedge clk) begin
        if (!rst_n)       status_q <= 1'b0;
        else if (expire)  status_q <= 1'b1;
        else if (clr_req) status_q <= 1'b0;
    end

    generate
        if (HI_W > 0) begin : g_hi
            logic [HI_W-1:0] hi_q;
            // High timeout byte; writing it does not reload the counter.
            always_ff @(posedge clk) begin
                if (!rst_n)               hi_q <= '0;
                else if (wsel == SEL_HI)  hi_q <= wr_data[HI_W-1:0];
            end
            assign hi_rd    = 8'(hi_q);
            assign load_val = {hi_q, wr_data};
        end else begin : g_no_hi
            assign hi_rd    = 8'h00;
            assign load_val = wr_data[CNT_W-1:0];
        end
    endgenerate

    // Combinational read mux.
    always_comb begin
        rd_data = 8'h00;
        case (decode(rd_addr))
            SEL_CTRL: rd_data[ST_FLAG_BIT] = status_q;
            SEL_CFG:  rd_data = cfg_q;
            SEL_LO:   rd_data = lo_q;
            SEL_HI:   rd_data = hi_rd;
            default:  rd_data = 8'h00;
        endcase
    end

    // R7: an expiry always leaves the flag set on the next cycle.
    p_flag_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
        expire |=> status_q);
    // R7: without a W1C write the flag never falls.
    p_flag_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (status_q && !clr_req) |=> status_q);
endmodule

// File: rtl/wdt_prescaler.sv
// Divide-by-DIV stage for minute mode: counts one-second ticks while
// enabled and flags the tick that completes a minute. A clear (reload)
// restarts the division from zero.
module wdt_prescaler #(
    parameter int DIV = 60
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic en,
    input  logic tick,
    output logic wrap
);
    localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);

    logic [CW-1:0] cnt;

    assign wrap = en && tick && (cnt == LAST);

    // Tick accumulator, cleared on reload.
    always_ff @(posedge clk) begin
        if (!rst_n || clr)  cnt <= '0;
        else if (en && tick) cnt <= (cnt == LAST) ? '0 : cnt + 1'b1;
    end

    // R4: the accumulator never reaches DIV.
    p_presc_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= LAST);
    // R4: a reload leaves the accumulator at zero.
    p_presc_clr_r4: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (cnt == '0));
endmodule

// File: rtl/wdt_downcount.sv
// Timeout down-counter. A load overrides everything; otherwise a step
// decrements a nonzero count. Reaching zero from one emits a single-cycle
// expire and the counter then rests at zero until the next load.
module wdt_downcount #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             step,
    output logic             running,
    output logic             expire
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic [CNT_W-1:0] cnt;

    assign running = (cnt != '0);
    assign expire  = !load && step && (cnt == ONE);

    // Count register: load, else decrement on step while nonzero.
    always_ff @(posedge clk) begin
        if (!rst_n)               cnt <= '0;
        else if (load)            cnt <= load_val;
        else if (running && step) cnt <= cnt - 1'b1;
    end

    // R12: a load installs the full combined value.
    p_load_val_r12: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (cnt == $past(load_val)));
    // R8: a stopped counter stays stopped until the next load.
    p_stay_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!running && !load) |=> !running);
    // R3: each step without load takes exactly one off a nonzero count.
    p_step_dec_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (running && step && !load) |=> (cnt == $past(cnt) - 1'b1));
    // R6: without step or load the count holds.
    p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!step && !load) |=> $stable(cnt));
endmodule

// File: rtl/wdt_pulse.sv
// Fixed-width pulse stretcher: a fire while enabled drives the output
// high for exactly WIDTH cycles, starting the next cycle.
module wdt_pulse #(
    parameter int WIDTH = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic fire,
    input  logic en,
    output logic pulse_o
);
    localparam int PW = $clog2(WIDTH + 1);
    localparam logic [PW-1:0] FULL = PW'(WIDTH);

    logic [PW-1:0] remain;

    assign pulse_o = (remain != '0);

    // Remaining high cycles of the current pulse.
    always_ff @(posedge clk) begin
        if (!rst_n)            remain <= '0;
        else if (fire && en)   remain <= FULL;
        else if (remain != '0) remain <= remain - 1'b1;
    end

    // R9: an enabled fire raises the output on the next cycle.
    p_pulse_start_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && en) |=> pulse_o);
    // R9: a disabled output never starts from idle.
    p_pulse_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!pulse_o && !(fire && en)) |=> !pulse_o);
    // R9: the remaining count never exceeds the width.
    p_pulse_bound_r9: assert property (@(posedge clk) disable iff (!rst_n)
        remain <= FULL);
endmodule

// File: rtl/sm_watchdog.sv
// Top of the second/minute countdown watchdog. Wires the register bank,
// the minute prescaler, the down-counter and one pulse stretcher per
// routed output. Assumes tick_1s is a one-cycle pulse in the clk domain.
module sm_watchdog
    import wdt_pkg::*;
#(
    parameter int         CNT_W     = 16,
    parameter int         MIN_DIV   = 60,
    parameter int         PULSE_CYC = 8,
    parameter logic [7:0] ADDR_CTRL = 8'h71,
    parameter logic [7:0] ADDR_CFG  = 8'h72,
    parameter logic [7:0] ADDR_LO   = 8'h73,
    parameter logic [7:0] ADDR_HI   = 8'h74
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick_1s,
    input  logic       wr_en,
    input  logic [7:0] wr_addr,
    input  logic [7:0] wr_data,
    input  logic [7:0] rd_addr,
    output logic [7:0] rd_data,
    output logic       expired_o,
    output logic       kbd_rst_o,
    output logic       pwrgood_rst_o,
    output logic       tmo_o
);
    logic [7:0]             cfg_q;
    logic                   load;
    logic [CNT_W-1:0]       load_val;
    logic                   running;
    logic                   expire;
    logic                   min_wrap;
    logic                   step;
    logic                   sec_mode;
    logic [N_PULSE_OUT-1:0] pulse_vec;

    assign sec_mode = cfg_q[CFG_SEC_BIT];
    assign step     = sec_mode ? tick_1s : min_wrap;

    wdt_regs #(
        .CNT_W(CNT_W), .ADDR_CTRL(ADDR_CTRL), .ADDR_CFG(ADDR_CFG),
        .ADDR_LO(ADDR_LO), .ADDR_HI(ADDR_HI)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .expire(expire),
        .rd_data(rd_data), .cfg_q(cfg_q), .status_q(expired_o),
        .load(load), .load_val(load_val)
    );

    wdt_prescaler #(.DIV(MIN_DIV)) u_presc (
        .clk(clk), .rst_n(rst_n), .clr(load), .en(running && !sec_mode),
        .tick(tick_1s), .wrap(min_wrap)
    );

    wdt_downcount #(.CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .load(load), .load_val(load_val),
        .step(step), .running(running), .expire(expire)
    );

    generate
        for (genvar k = 0; k < N_PULSE_OUT; k++) begin : g_pulse
            wdt_pulse #(.WIDTH(PULSE_CYC)) u_pulse (
                .clk(clk), .rst_n(rst_n), .fire(expire),
                .en(cfg_q[pulse_en_bit(k)]), .pulse_o(pulse_vec[k])
            );
        end
    endgenerate

    assign kbd_rst_o     = pulse_vec[0];
    assign pwrgood_rst_o = pulse_vec[1];
    assign tmo_o         = pulse_vec[2];

    // R5: once stopped with no load, the flag cannot newly rise.
    p_stopped_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!running && !load && !expired_o) |=> !expired_o);
endmodule

// File: tb/sm_watchdog_test.sv
// Directed bench for sm_watchdog: one task per scenario.
module sm_watchdog_test;
    localparam int PULSE = 8;
    localparam int DIV   = 60;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_1s = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_addr = 8'h00;
    logic [7:0] wr_data = 8'h00;
    logic [7:0] rd_addr = 8'h00;
    logic [7:0] rd_data;
    logic       expired_o, kbd_rst_o, pwrgood_rst_o, tmo_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    sm_watchdog #(.PULSE_CYC(PULSE), .MIN_DIV(DIV)) uut (
        .clk(clk), .rst_n(rst_n), .tick_1s(tick_1s), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
        .rd_data(rd_data), .expired_o(expired_o), .kbd_rst_o(kbd_rst_o),
        .pwrgood_rst_o(pwrgood_rst_o), .tmo_o(tmo_o)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output int d);
        @(negedge clk);
        rd_addr = a;
        #1 d = int'(rd_data);
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); tick_1s = 1'b1;
            @(negedge clk); tick_1s = 1'b0;
            #1;
        end
    endtask

    task automatic clear_flag();
        wr(8'h71, 8'h01);
    endtask

    task t_reset();
        int d;
        rd(8'h71, d); chk("R1 ctrl", d, 0);
        rd(8'h72, d); chk("R1 cfg", d, 0);
        rd(8'h73, d); chk("R1 lo", d, 0);
        chk("R1 outputs", int'({kbd_rst_o, pwrgood_rst_o, tmo_o}), 0);
        ticks(5);
        chk("R1 stopped", int'(expired_o), 0);
    endtask

    task t_regs();
        int d;
        wr(8'h72, 8'hA5); rd(8'h72, d); chk("R2 cfg readback", d, 8'hA5);
        wr(8'h74, 8'h12); rd(8'h74, d); chk("R2 hi readback", d, 8'h12);
        wr(8'h73, 8'h3C); rd(8'h73, d); chk("R2 lo readback", d, 8'h3C);
        wr(8'h74, 8'h00); wr(8'h73, 8'h00);
        wr(8'h72, 8'h00);
    endtask

    task t_seconds();
        int d;
        wr(8'h72, 8'h80);
        wr(8'h73, 8'd5);
        ticks(4); chk("R3 before N", int'(expired_o), 0);
        ticks(1); chk("R3 at N", int'(expired_o), 1);
        chk("R9 kbd disabled", int'(kbd_rst_o), 0);
        chk("R10 pwr disabled", int'(pwrgood_rst_o), 0);
        chk("R11 tmo disabled", int'(tmo_o), 0);
        wr(8'h71, 8'h00); rd(8'h71, d); chk("R7 write 0 keeps", d, 1);
        wr(8'h71, 8'h01); rd(8'h71, d); chk("R7 write 1 clears", d, 0);
        ticks(10); chk("R8 no re-expiry", int'(expired_o), 0);
    endtask

    task t_keepalive();
        wr(8'h73, 8'd4);
        ticks(3);
        wr(8'h73, 8'd4);
        ticks(3); chk("R6 restarted", int'(expired_o), 0);
        ticks(1); chk("R6 full period", int'(expired_o), 1);
        clear_flag();
    endtask

    task t_stop();
        wr(8'h73, 8'd3);
        ticks(1);
        wr(8'h73, 8'd0);
        ticks(10); chk("R5 zero stops", int'(expired_o), 0);
    endtask

    task t_high();
        wr(8'h73, 8'd3);
        wr(8'h74, 8'd5);
        ticks(2); chk("R12 hi write no reload early", int'(expired_o), 0);
        ticks(1); chk("R12 hi write no reload", int'(expired_o), 1);
        clear_flag();
        wr(8'h74, 8'd1);
        wr(8'h73, 8'd2);
        ticks(257); chk("R12 combined before", int'(expired_o), 0);
        ticks(1);   chk("R12 combined at 258", int'(expired_o), 1);
        clear_flag();
        wr(8'h74, 8'd0);
    endtask

    task t_minutes();
        wr(8'h72, 8'h00);
        wr(8'h73, 8'd1);
        ticks(30);
        wr(8'h73, 8'd1);
        ticks(DIV - 1); chk("R4 prescaler cleared", int'(expired_o), 0);
        ticks(1);       chk("R4 one minute", int'(expired_o), 1);
        clear_flag();
        wr(8'h73, 8'd2);
        ticks(2 * DIV - 1); chk("R4 two minutes early", int'(expired_o), 0);
        ticks(1);           chk("R4 two minutes", int'(expired_o), 1);
        clear_flag();
    endtask

    // Fire one expiry and count high cycles on each pulse output.
    task automatic measure(input logic [7:0] cfg, output int nk,
                           output int np, output int nt);
        nk = 0; np = 0; nt = 0;
        wr(8'h72, cfg);
        wr(8'h73, 8'd2);
        ticks(2);
        for (int i = 0; i < PULSE + 4; i++) begin
            nk += int'(kbd_rst_o); np += int'(pwrgood_rst_o); nt += int'(tmo_o);
            @(negedge clk); #1;
        end
        clear_flag();
    endtask

    task t_pulses();
        int nk, np, nt;
        measure(8'hC0, nk, np, nt);
        chk("R9 kbd width", nk, PULSE); chk("R10 pwr off", np, 0); chk("R11 tmo off", nt, 0);
        measure(8'h90, nk, np, nt);
        chk("R10 pwr width", np, PULSE); chk("R9 kbd off", nk, 0);
        measure(8'hA0, nk, np, nt);
        chk("R11 tmo width", nt, PULSE); chk("R10 pwr off b", np, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_regs();
        t_seconds();
        t_keepalive();
        t_stop();
        t_high();
        t_minutes();
        t_pulses();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual hung expected done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule